// File: doc/BRIEF.md
# SPI Serial EEPROM Target Model

This block acts as the target side of an SPI link and behaves like a small byte-wide serial EEPROM. The default array holds 1024 bytes. A controller lowers chip select and shifts in an 8-bit command. Depending on the command, it then sends a 16-bit address and data bytes, or clocks out data or status. SCK, chip select and MOSI are brought into the system clock domain by two-stage synchronizers. All decoding runs on the system clock, so SCK must be several times slower than the system clock.

A write happens in two frames. The first frame sets a write-enable latch. The second frame fills a page buffer, which is copied into the array only when chip select rises at a clean byte boundary. After the copy, a busy window runs for a programmable number of system clocks. The write-enable latch clears when that window ends. Software polls the status byte to see when the write has finished. Reads stream bytes starting at any address, and the pointer moves across page boundaries without stopping.

Top module: `spi_eeprom_target`

## Requirements
- R1: After reset the whole array reads 0x00, the status byte is 0x00 and MISO is 0.
- R2: A frame made of exactly the single command 0x06 sets the write-enable latch when chip select rises, provided no write cycle is running. The status byte carries write-in-progress in bit 0 and the write-enable latch in bit 1; its other bits read 0.
- R3: A write command (0x02) received while the write-enable latch is clear changes nothing: the array is not written and no busy window starts.
- R4: A write frame is committed only if chip select rises with no partial bit count and at least one full data byte has been received. If chip select rises partway through a byte, the whole frame is discarded and the latch keeps its value.
- R5: During a write the pointer steps only within its 16-byte page, so its low four bits wrap from 1111 back to 0000. A later byte that lands on the same page slot replaces the earlier one.
- R6: The 16-bit address arrives high byte first, and the top six bits are ignored. A read (0x03) returns bytes from successive addresses across page boundaries and wraps from 0x3FF to 0x000.
- R7: In the byte after command 0x05, MISO carries the status byte. Write-in-progress reads 1 from the commit until the programmed number of system clocks has elapsed.
- R8: The write-enable latch clears at the moment the write cycle completes.
- R9: While a write cycle is running, read, write and write-enable commands are ignored: reads return 0x00 bytes and no array content changes.
- R10: Bits are sampled on rising SCK and sent MSB first, and SPI modes 0 and 3 both work.
- R11: MISO stays 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock from the controller |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller |

## Verification
The assertions assume three things about the controller. SCK half-periods and the gaps around chip select edges last several system clocks, so each synchronized edge is seen on its own. Chip select changes only while SCK is idle. MOSI is stable across each rising SCK. The bench drives every SPI edge eight system clocks apart and moves chip select only with SCK at rest, in both modes. Random addresses, lengths, data and modes then stay inside those limits.

// File: rtl/spi_eeprom_target.sv
module spi_eeprom_target #(
  parameter int ADDR_BITS = 10,
  parameter int PAGE_BITS = 4,
  parameter int TWC_CLKS  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int PAGE  = 1 << PAGE_BITS;
  localparam int CW    = $clog2(TWC_CLKS + 1);
  localparam logic [7:0] OP_WEN = 8'h06, OP_WR = 8'h02, OP_RD = 8'h03, OP_ST = 8'h05;

  typedef enum logic [2:0] {P_CMD, P_WEN, P_AH, P_AL, P_WR, P_RD, P_ST, P_SKIP} phase_t;

  logic [2:0] sck_p, cs_p;
  logic [1:0] mosi_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0; cs_p <= '1; mosi_p <= '0;
    end else begin
      sck_p <= {sck_p[1:0], sck};
      cs_p <= {cs_p[1:0], cs_n};
      mosi_p <= {mosi_p[0], mosi};
    end

  wire sck_rise = sck_p[1] & ~sck_p[2];
  wire sck_fall = ~sck_p[1] & sck_p[2];
  wire cs_low   = ~cs_p[1];
  wire cs_fall  = ~cs_p[1] & cs_p[2];
  wire cs_rise  = cs_p[1] & ~cs_p[2];

  phase_t phase;
  logic [2:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh, op;
  logic [ADDR_BITS-1:0] ptr;
  logic [PAGE-1:0] pmask;
  logic [7:0] pbuf [PAGE];
  logic [7:0] mem [DEPTH];
  logic wel;
  logic [CW-1:0] wcnt;

  wire wip = (wcnt != '0);
  wire [7:0] status = {6'b0, wel, wip};
  wire [7:0] rx_byte = {rx_sh[6:0], mosi_p[1]};
  wire byte_done = cs_low & ~cs_fall & sck_rise & (bit_cnt == 3'd7);
  wire [ADDR_BITS-1:0] start_addr = {ptr[ADDR_BITS-1:8], rx_byte};
  wire commit = cs_rise & (phase == P_WR) & (bit_cnt == 3'd0) & (|pmask) & wel & ~wip;
  wire wen_set = cs_rise & (phase == P_WEN) & (bit_cnt == 3'd0) & ~wip;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= P_CMD; bit_cnt <= '0; rx_sh <= '0; tx_sh <= '0; op <= '0;
      ptr <= '0; pmask <= '0;
    end else if (cs_fall) begin
      phase <= P_CMD; bit_cnt <= '0; pmask <= '0;
    end else if (cs_low) begin
      if (sck_rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        rx_sh <= rx_byte;
        if (bit_cnt == 3'd7) begin
          case (phase)
            P_CMD: begin
              op <= rx_byte;
              case (rx_byte)
                OP_WEN: phase <= P_WEN;
                OP_WR:  phase <= (wel && !wip) ? P_AH : P_SKIP;
                OP_RD:  phase <= !wip ? P_AH : P_SKIP;
                OP_ST:  begin phase <= P_ST; tx_sh <= status; end
                default: phase <= P_SKIP;
              endcase
            end
            P_WEN: phase <= P_SKIP;
            P_AH: begin
              ptr[ADDR_BITS-1:8] <= rx_byte[ADDR_BITS-9:0];
              phase <= P_AL;
            end
            P_AL:
              if (op == OP_RD) begin
                tx_sh <= mem[start_addr];
                ptr <= start_addr + 1'b1;
                phase <= P_RD;
              end else begin
                ptr <= start_addr;
                phase <= P_WR;
              end
            P_WR: begin
              pmask[ptr[PAGE_BITS-1:0]] <= 1'b1;
              ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + 1'b1;
            end
            P_RD: begin
              tx_sh <= mem[ptr];
              ptr <= ptr + 1'b1;
            end
            P_ST: tx_sh <= status;
            default: ;
          endcase
        end
      end else if (sck_fall && bit_cnt != 3'd0) begin
        tx_sh <= {tx_sh[6:0], 1'b0};
      end
    end

  always_ff @(posedge clk)
    if (byte_done && phase == P_WR) pbuf[ptr[PAGE_BITS-1:0]] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++)
        if (pmask[i]) mem[{ptr[ADDR_BITS-1:PAGE_BITS], PAGE_BITS'(i)}] <= pbuf[i];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wel <= 1'b0; wcnt <= '0;
    end else begin
      if (commit) wcnt <= CW'(TWC_CLKS);
      else if (wip) wcnt <= wcnt - 1'b1;
      if (wen_set) wel <= 1'b1;
      else if (wcnt == CW'(1)) wel <= 1'b0;
    end

  assign miso = cs_low & ((phase == P_RD) | (phase == P_ST)) & tx_sh[7];

  AST_WEL_SET_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_rise) && !$past(wip)); // R2
  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel) && $past(cs_rise)); // R3
  AST_BUSY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && $past(wip)) |-> wcnt < $past(wcnt)); // R7
  AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel); // R8
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !miso); // R11
endmodule

// File: tb/sim_spi_eeprom_target.sv
module sim_spi_eeprom_target;
  localparam int CLK_NS = 10;
  localparam int HALF = 8;
  localparam int TWC = 4000;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0;
  logic miso;
  int total = 0, bad = 0;
  logic mode3 = 0;
  logic [7:0] ref_mem [1024];
  logic [7:0] tx [40];
  logic [7:0] rx [40];

  always #(CLK_NS/2) clk = ~clk;

  spi_eeprom_target #(.ADDR_BITS(10), .PAGE_BITS(4), .TWC_CLKS(TWC)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  task automatic wait_cy(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input bit busy, input bit latch);
    return {6'b0, latch, busy};
  endfunction

  function automatic logic [9:0] wr_slot(input logic [15:0] a, input int i);
    logic [3:0] lo;
    lo = a[3:0] + 4'(i);
    return {a[9:4], lo};
  endfunction

  task automatic frame(input int nbytes, input int extra_bits);
    int last;
    last = (extra_bits > 0) ? nbytes + 1 : nbytes;
    sck = mode3;
    wait_cy(HALF);
    cs_n = 0;
    wait_cy(HALF);
    for (int b = 0; b < last; b++) begin
      for (int i = 0; i < ((b < nbytes) ? 8 : extra_bits); i++) begin
        if (mode3) sck = 0;
        mosi = tx[b][7-i];
        wait_cy(HALF);
        rx[b][7-i] = miso;
        sck = 1;
        wait_cy(HALF);
        if (!mode3) sck = 0;
      end
    end
    wait_cy(HALF);
    cs_n = 1;
    wait_cy(2*HALF);
  endtask

  task automatic wren();
    tx[0] = 8'h06;
    frame(1, 0);
  endtask

  task automatic rdsr(output logic [7:0] s);
    tx[0] = 8'h05; tx[1] = 8'h00;
    frame(2, 0);
    s = rx[1];
  endtask

  task automatic write_bytes(input logic [15:0] a, input int n, input int extra);
    tx[0] = 8'h02; tx[1] = a[15:8]; tx[2] = a[7:0];
    frame(3 + n, extra);
  endtask

  task automatic model_write(input logic [15:0] a, input int n);
    for (int i = 0; i < n; i++) ref_mem[wr_slot(a, i)] = tx[3+i];
  endtask

  task automatic read_bytes(input logic [15:0] a, input int n);
    tx[0] = 8'h03; tx[1] = a[15:8]; tx[2] = a[7:0];
    for (int i = 0; i < n; i++) tx[3+i] = 8'h00;
    frame(3 + n, 0);
  endtask

  task automatic verify_read(input logic [15:0] a, input int n, input string req);
    read_bytes(a, n);
    for (int i = 0; i < n; i++) chk8(req, rx[3+i], ref_mem[10'(a + 16'(i))]);
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    int polls = 0;
    s = 8'h01;
    while (s[0] && polls < 100) begin
      rdsr(s);
      polls++;
    end
    chk8("R7 ready", {7'b0, s[0]}, 8'h00);
  endtask

  initial begin
    #(CLK_NS * 190000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] s;
    for (int i = 0; i < 1024; i++) ref_mem[i] = 8'h00;
    void'($urandom(32'd4242));
    wait_cy(4);
    rst_n = 1;
    wait_cy(5);
    chk8("R1 miso", {7'b0, miso}, 8'h00);
    rdsr(s); chk8("R1 status", s, exp_status(0, 0));
    verify_read(16'h0123, 2, "R1 array");

    tx[3] = 8'hAA;
    write_bytes(16'h0010, 1, 0);
    rdsr(s); chk8("R3 no busy", s, exp_status(0, 0));
    verify_read(16'h0010, 1, "R3 array");

    wren();
    rdsr(s); chk8("R2 latch", s, exp_status(0, 1));

    tx[3] = 8'h55; tx[4] = 8'hF0;
    write_bytes(16'h0040, 1, 3);
    rdsr(s); chk8("R4 abandoned", s, exp_status(0, 1));
    verify_read(16'h0040, 1, "R4 array");

    mode3 = 1;
    tx[3] = 8'h11; tx[4] = 8'h22; tx[5] = 8'h33;
    write_bytes(16'h001E, 3, 0);
    model_write(16'h001E, 3);
    rdsr(s); chk8("R7 busy", s, exp_status(1, 1));
    read_bytes(16'h001E, 2);
    chk8("R9 read busy", rx[3], 8'h00);
    chk8("R9 read busy", rx[4], 8'h00);
    wren();
    tx[3] = 8'h77;
    write_bytes(16'h0050, 1, 0);
    wait_ready();
    rdsr(s); chk8("R8 latch cleared", s, exp_status(0, 0));
    verify_read(16'h0010, 16, "R5 wrap");
    verify_read(16'h0050, 1, "R9 write busy");
    chk8("R11 idle", {7'b0, miso}, 8'h00);

    mode3 = 0;
    wren();
    tx[3] = 8'hC1; tx[4] = 8'hC2;
    write_bytes(16'hA7FE, 2, 0);
    model_write(16'hA7FE, 2);
    wait_ready();
    wren();
    tx[3] = 8'hD0;
    write_bytes(16'h0000, 1, 0);
    model_write(16'h0000, 1);
    wait_ready();
    verify_read(16'hFFFE, 4, "R6 wrap");
    verify_read(16'h03F0, 17, "R6 page cross");

    for (int it = 0; it < 6; it++) begin
      logic [15:0] a;
      int n;
      a = 16'($urandom_range(0, 16'hFFFF));
      n = $urandom_range(1, 20);
      mode3 = 1'($urandom_range(0, 1));
      wren();
      for (int i = 0; i < n; i++) tx[3+i] = 8'($urandom_range(0, 255));
      write_bytes(a, n, 0);
      model_write(a, n);
      wait_ready();
      verify_read({a[15:4], 4'h0}, 16, "R10 random");
      chk8("R11 idle", {7'b0, miso}, 8'h00);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule